// File: doc/BRIEF.md
# SPI Flash Command and Status Controller

This block is the command front end of a small two-sector on-chip flash, reached over SPI as a slave. It samples SCK, chip select and serial input in the system clock domain. While chip select is low it shifts in an 8-bit opcode, MSB first, one bit per SCK rising edge. Nothing executes on the last opcode bit. The decoded command takes effect only in the cycle in which chip select returns high, and only if exactly eight or more bits were shifted in. Bits after the eighth are ignored.

The controller keeps a write-enable latch and a busy flag. An accepted sector or chip erase raises a one-cycle request to the flash model, carrying a sector mask. Busy stays asserted until the flash model returns a done pulse. Chip erase covers both sectors in extended mode and only sector 0 in base mode. In read-only mode the status register does not exist, so write enable has no effect. The serial output is never driven, because every supported command is opcode-only.

Top module: `spi_flash_cmd_ctrl`

## Requirements
- R1: After reset, wen_o, busy_o and erase_req_o are 0.
- R2: Opcode 0x06 (write enable) sets wen_o when chip select rises after the eighth bit. wen_o does not change before that rise.
- R3: Opcode 0x04 (write disable) clears wen_o. Sector erase and chip erase leave wen_o unchanged.
- R4: If chip select rises with fewer than 8 bits shifted in, no action is taken. Bits after the eighth are ignored, and the first eight bits form the opcode.
- R5: Opcode 0x20 (sector erase) with wen_o=1 and prot_i[0]=0 produces a one-cycle erase_req_o pulse after chip select rises, with erase_sect_o=2'b01, and sets busy_o.
- R6: Opcode 0x60 (chip erase) gives erase_sect_o=2'b11 when mode_ext_i=1 and 2'b01 when mode_ext_i=0.
- R7: An erase is ignored when wen_o=0 or when any targeted sector has its protect bit set (prot_i bit i guards sector i).
- R8: busy_o stays 1 until erase_done_i is sampled high, then clears on the next cycle.
- R9: While busy_o=1, erase and write-enable commands are ignored. Write disable still clears wen_o.
- R10: With read_only_i=1, write enable leaves wen_o unchanged.
- R11: Any other complete opcode produces no request and no change to wen_o or busy_o.
- R12: so_oe_o stays 0, so the serial output remains at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI clock, synchronous to clk_i |
| cs_ni | input | 1 | SPI chip select, active low |
| si_i | input | 1 | SPI serial data in |
| so_oe_o | output | 1 | Serial output enable; 0 means high impedance |
| mode_ext_i | input | 1 | 1 selects extended mode (chip erase covers both sectors) |
| read_only_i | input | 1 | 1 means no status register exists |
| prot_i | input | NUM_SECT | Per-sector protect bits |
| erase_req_o | output | 1 | One-cycle erase start pulse |
| erase_sect_o | output | NUM_SECT | Sectors to erase, held while busy |
| erase_done_i | input | 1 | Completion pulse from the flash model |
| wen_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Erase in progress (inverse of ready) |

## Verification
The bench goes after commands whose effect could leak out early. It checks wen_o and the request counter after the eighth bit but before chip select rises, so a design that executes on the last bit is caught. Truncated and over-long frames are checked as well: a design that counts past eight would take the wrong opcode, and one that acts on a partial opcode would set the latch or erase. Commands are issued while an erase is in flight; a design that fails to block them would issue a second request or re-set a cleared latch. Random mixes of modes and protect bits catch a chip erase that targets the wrong sector mask or ignores protection on sector 1.

// File: rtl/spi_flash_cmd_pkg.sv
package spi_flash_cmd_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OPC_WREN = 8'h06;
  localparam logic [OP_W-1:0] OPC_WRDI = 8'h04;
  localparam logic [OP_W-1:0] OPC_SE   = 8'h20;
  localparam logic [OP_W-1:0] OPC_CE   = 8'h60;
  typedef enum logic [2:0] {CMD_NONE, CMD_WREN, CMD_WRDI, CMD_SE, CMD_CE} cmd_e;
endpackage

// File: rtl/spi_op_shift.sv
module spi_op_shift #(
  parameter int OP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            cs_ni,
  input  logic            si_i,
  output logic [OP_W-1:0] op_o,
  output logic            full_o,
  output logic            cs_rise_o
);
  localparam int CNT_W = $clog2(OP_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_W);

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  sr_q;
  logic             sck_rise;

  assign sck_rise  = sck_i & ~sck_q & ~cs_ni;
  assign cs_rise_o = cs_ni & ~cs_q;
  assign full_o    = (cnt_q == CNT_FULL);
  assign op_o      = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (sck_rise && !full_o) begin
        // wait state after a full opcode: extra bits dropped
        cnt_q <= cnt_q + 1'b1;
        sr_q  <= {sr_q[OP_W-2:0], si_i};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 2
) (
  input  logic [OP_W-1:0]     op_i,
  input  logic                full_i,
  input  logic                mode_ext_i,
  output cmd_e                cmd_o,
  output logic [NUM_SECT-1:0] mask_o
);
  localparam logic [NUM_SECT-1:0] MASK_S0  = NUM_SECT'(1);
  localparam logic [NUM_SECT-1:0] MASK_ALL = '1;

  always_comb begin
    cmd_o  = CMD_NONE;
    mask_o = '0;
    if (full_i) begin
      unique case (op_i)
        OPC_WREN: cmd_o = CMD_WREN;
        OPC_WRDI: cmd_o = CMD_WRDI;
        OPC_SE: begin
          cmd_o  = CMD_SE;
          mask_o = MASK_S0;
        end
        OPC_CE: begin
          cmd_o  = CMD_CE;
          mask_o = mode_ext_i ? MASK_ALL : MASK_S0;
        end
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
  import spi_flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_rise_i,
  input  cmd_e                cmd_i,
  input  logic [NUM_SECT-1:0] mask_i,
  input  logic                read_only_i,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic                erase_done_i,
  output logic                wen_o,
  output logic                busy_o,
  output logic                erase_req_o,
  output logic [NUM_SECT-1:0] erase_sect_o
);
  logic is_erase, go_erase;

  assign is_erase = (cmd_i == CMD_SE) || (cmd_i == CMD_CE);
  assign go_erase = cs_rise_i && is_erase && !busy_o && wen_o
                    && ((mask_i & prot_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o        <= 1'b0;
      busy_o       <= 1'b0;
      erase_req_o  <= 1'b0;
      erase_sect_o <= '0;
    end else begin
      erase_req_o <= go_erase;
      if (go_erase) begin
        busy_o       <= 1'b1;
        erase_sect_o <= mask_i;
      end else if (busy_o && erase_done_i) begin
        busy_o <= 1'b0;
      end
      if (cs_rise_i) begin
        if (cmd_i == CMD_WRDI) wen_o <= 1'b0;
        else if (cmd_i == CMD_WREN && !busy_o && !read_only_i) wen_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_cmd_ctrl.sv
module spi_flash_cmd_ctrl
  import spi_flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                si_i,
  output logic                so_oe_o,
  input  logic                mode_ext_i,
  input  logic                read_only_i,
  input  logic [NUM_SECT-1:0] prot_i,
  output logic                erase_req_o,
  output logic [NUM_SECT-1:0] erase_sect_o,
  input  logic                erase_done_i,
  output logic                wen_o,
  output logic                busy_o
);
  logic [OP_W-1:0]     op;
  logic                full, cs_rise;
  cmd_e                cmd;
  logic [NUM_SECT-1:0] mask;

  // opcode-only command set: output never driven
  assign so_oe_o = 1'b0;

  spi_op_shift #(.OP_W(OP_W)) shift_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni), .si_i(si_i),
    .op_o(op), .full_o(full), .cs_rise_o(cs_rise)
  );

  spi_cmd_decode #(.NUM_SECT(NUM_SECT)) dec_i (
    .op_i(op), .full_i(full), .mode_ext_i(mode_ext_i), .cmd_o(cmd), .mask_o(mask)
  );

  spi_erase_ctrl #(.NUM_SECT(NUM_SECT)) ctl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_rise_i(cs_rise), .cmd_i(cmd), .mask_i(mask),
    .read_only_i(read_only_i), .prot_i(prot_i), .erase_done_i(erase_done_i),
    .wen_o(wen_o), .busy_o(busy_o), .erase_req_o(erase_req_o), .erase_sect_o(erase_sect_o)
  );
endmodule

// File: rtl/spi_flash_cmd_ctrl_chk.sv
module spi_flash_cmd_ctrl_chk #(
  parameter int NUM_SECT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic [NUM_SECT-1:0] prot_i,
  input logic                erase_req_o,
  input logic [NUM_SECT-1:0] erase_sect_o,
  input logic                erase_done_i,
  input logic                wen_o,
  input logic                busy_o
);
  AST_REQ_AFTER_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(cs_ni)); // R5
  AST_REQ_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> wen_o); // R7
  AST_REQ_UNPROTECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> ((erase_sect_o & $past(prot_i)) == '0)); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !erase_done_i) |=> busy_o); // R8
  AST_BUSY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && erase_done_i) |=> !busy_o); // R8
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !erase_done_i) |=> !erase_req_o); // R9
  AST_WEN_ON_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen_o) |-> $past(cs_ni)); // R2
endmodule

bind spi_flash_cmd_ctrl spi_flash_cmd_ctrl_chk #(.NUM_SECT(NUM_SECT)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .prot_i(prot_i),
  .erase_req_o(erase_req_o), .erase_sect_o(erase_sect_o), .erase_done_i(erase_done_i),
  .wen_o(wen_o), .busy_o(busy_o)
);

// File: tb/spi_flash_cmd_ctrl_tb_top.sv
module spi_flash_cmd_ctrl_tb_top;
  localparam int NS = 2;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so_oe, ext = 1'b1, ro = 1'b0, done = 1'b0;
  logic [NS-1:0] prot = '0;
  logic req, wen, busy;
  logic [NS-1:0] sect;

  int n_chk = 0, n_bad = 0, req_cnt = 0;
  logic [NS-1:0] req_mask;
  bit m_wen = 1'b0, m_busy = 1'b0;

  always #4 clk = ~clk;

  spi_flash_cmd_ctrl #(.NUM_SECT(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_oe_o(so_oe), .mode_ext_i(ext), .read_only_i(ro), .prot_i(prot),
    .erase_req_o(req), .erase_sect_o(sect), .erase_done_i(done),
    .wen_o(wen), .busy_o(busy)
  );

  always @(negedge clk) if (req) begin req_cnt <= req_cnt + 1; req_mask <= sect; end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R3 R5 R6 R7 R9 R10 R11 expected effect of a frame
  task automatic model(input logic [15:0] bits, input int nb, output bit ereq, output logic [NS-1:0] emask);
    logic [7:0] op;
    op = bits[15:8];
    ereq = 1'b0; emask = '0;
    if (nb < 8) return;
    case (op)
      8'h06: if (!m_busy && !ro) m_wen = 1'b1;
      8'h04: m_wen = 1'b0;
      8'h20, 8'h60: begin
        emask = (op == 8'h60 && ext) ? 2'b11 : 2'b01;
        if (!m_busy && m_wen && ((emask & prot) == '0)) begin
          ereq = 1'b1; m_busy = 1'b1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [15:0] bits, input int nb, input string r);
    bit ereq; logic [NS-1:0] emask; bit pre_wen;
    pre_wen = m_wen;
    req_cnt = 0;
    cs_n = 1'b0; cyc(2);
    for (int i = 0; i < nb; i++) begin
      si = bits[15-i]; cyc(2);
      sck = 1'b1; cyc(2);
      sck = 1'b0;
      chk(so_oe == 1'b0, "R12", so_oe, 0);
    end
    cyc(2);
    chk(wen == pre_wen, "R2 before cs rise", wen, pre_wen);
    chk(req_cnt == 0, "R5 before cs rise", req_cnt, 0);
    cs_n = 1'b1;
    model(bits, nb, ereq, emask);
    cyc(3);
    chk(wen == m_wen, {r, " wen"}, wen, m_wen);
    chk(busy == m_busy, {r, " busy"}, busy, m_busy);
    chk(req_cnt == int'(ereq), {r, " req"}, req_cnt, ereq);
    if (ereq) chk(req_mask == emask, {r, " mask R6"}, req_mask, emask);
  endtask

  task automatic finish_erase(input int wait_n);
    cyc(wait_n);
    chk(busy == 1'b1, "R8 hold", busy, 1);
    done = 1'b1; cyc(1); done = 1'b0; cyc(1);
    m_busy = 1'b0;
    chk(busy == 1'b0, "R8 clear", busy, 0);
  endtask

  bit fin = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    cyc(3); rst_ni = 1'b1; cyc(2);
    chk(wen == 0 && busy == 0 && req == 0, "R1", {wen, busy, req}, 0);

    frame(16'h0600, 8, "R10 ro wren");          // ro=0 first: sets
    frame(16'h0400, 8, "R3 wrdi");
    ro = 1'b1; frame(16'h0600, 8, "R10 ro wren"); ro = 1'b0;
    frame(16'h2000, 8, "R7 se no wen");
    frame(16'h0600, 5, "R4 partial");
    frame(16'h0600, 8, "R2 wren");
    frame(16'h04FF, 14, "R4 extra bits");       // first byte wrdi
    frame(16'h0600, 8, "R2 wren");
    frame(16'h5A00, 8, "R11 unknown");
    prot = 2'b10; ext = 1'b1;
    frame(16'h6000, 8, "R7 ce prot s1");
    ext = 1'b0;
    frame(16'h6000, 8, "R6 ce base");
    frame(16'h6000, 8, "R9 ce busy");
    frame(16'h0400, 8, "R9 wrdi busy");
    frame(16'h0600, 8, "R9 wren busy");
    finish_erase(4);
    prot = 2'b00; ext = 1'b1;
    frame(16'h0600, 8, "R2 wren");
    frame(16'h6000, 8, "R6 ce ext");
    finish_erase(1);
    frame(16'h2000, 8, "R3 se keeps wen");
    finish_erase(2);

    for (int it = 0; it < 250; it++) begin
      logic [15:0] bits; int nb, sel;
      bits = 16'($urandom());
      sel = $urandom_range(0, 4);
      case (sel)
        0: bits[15:8] = 8'h06; 1: bits[15:8] = 8'h04;
        2: bits[15:8] = 8'h20; 3: bits[15:8] = 8'h60; default: ;
      endcase
      nb = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 16) : 8;
      ext = 1'($urandom());
      ro = ($urandom_range(0, 7) == 0);
      prot = ($urandom_range(0, 2) == 0) ? NS'($urandom()) : '0;
      frame(bits, nb, "R5 rand");
      if (m_busy && $urandom_range(0, 2) != 0) finish_erase($urandom_range(0, 6));
    end
    if (m_busy) finish_erase(1);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule